// File: doc/BRIEF.md
# Latching Multichannel Event Scaler

A bank of parameterised counters, one per input channel. Each counter counts rising edges of its input after a two-flop synchroniser. When a trigger is accepted, every counter is copied into its own latch on the same clock edge. The counters keep running. If the auto-clear option is on, they restart from zero on that edge instead.

An event builder then turns the latched snapshot into a variable-length event in a multi-event FIFO. The event has three parts, in this order:
- a header word;
- an optional time-tag word, taken from a free-running microsecond counter;
- the latched values of the channels selected by an enable mask, lowest channel first.

A host drains the FIFO through a show-ahead read port (`rd_valid`, `rd_data`, `pop`). It can also read any counter's live value at a byte address of four times the channel index. A trigger is refused when the FIFO lacks room for a worst-case event under the current mask. It is also refused while a previous event is still being serialised.

Top module: `evscal_top`

## Requirements
- R1: Each channel counter adds one for every rising edge seen on its synchronised input and wraps modulo 2^CNT_W; it never changes by more than one per clock.
- R2: An accepted trigger copies every counter into its latch on the same edge; edges arriving while the event is being written keep being counted and do not alter the event.
- R3: An event is a header word, then the time tag if enabled, then the latched values of enabled channels in ascending channel order. Header bit 31 = time tag present, bits 30:16 = 15-bit event number (0 for the first accepted event after reset, +1 per accepted event), bits 15:0 = total event length in words including the header.
- R4: The time tag is the number of whole microseconds (TICKS_PER_US clocks each) elapsed since reset, captured at trigger acceptance.
- R5: A trigger is accepted only when the builder is idle and the FIFO free space is at least 2 + the number of enabled channels; `full` is high exactly when that space test fails, and a refused trigger produces no event and does not advance the event number.
- R6: `rd_valid` is high while the FIFO holds a word, `rd_data` shows the oldest word, and `pop` removes it; `pop` on an empty FIFO has no effect.
- R7: With `auto_clr` high, an accepted trigger clears all counters as it latches them; a rising edge counted on that same edge leaves the counter at 1.
- R8: `live_data` returns the live counter of channel `live_addr >> 2`; the two low address bits are ignored.
- R9: After reset all counters read 0, the FIFO is empty, `full` is low, the event number is 0 and the time tag restarts from 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ch_in | input | NCH | Asynchronous channel inputs |
| trig | input | 1 | Trigger request, sampled each clock |
| chan_mask | input | NCH | Channel enable mask for events |
| tag_en | input | 1 | Include time-tag word in events |
| auto_clr | input | 1 | Clear counters on each accepted trigger |
| live_addr | input | log2(NCH)+2 | Byte address for live counter read |
| live_data | output | CNT_W | Live value of the addressed counter |
| rd_valid | output | 1 | FIFO holds at least one word |
| rd_data | output | 32 | Oldest FIFO word |
| pop | input | 1 | Remove the oldest FIFO word |
| full | output | 1 | A trigger now would be refused for lack of space |

## Verification
The bench sweeps all sixteen masks of a four-channel build, with alternating tag settings. A builder that got the channel order or skipping wrong would then emit mis-ordered or extra words, and a wrong size field would show in the header.

It fills the FIFO until the free space is exactly the requirement for one more event. A check that is off by one would then refuse a valid trigger or overfill the FIFO. A refused trigger that still bumps the event number shows up as a gap in the numbering.

Edges are injected while an event is being written, to catch a latch that tracks the live counter. An edge is also timed to land on the auto-clear edge; a design that drops it would latch 0 where 1 is expected on the next event.

// File: rtl/evscal_pkg.sv
package evscal_pkg;

   typedef enum logic [1:0] {
      BLD_IDLE = 2'd0,
      BLD_HDR  = 2'd1,
      BLD_TAG  = 2'd2,
      BLD_DATA = 2'd3
   } bld_state_e;

   localparam int WORD_W  = 32;
   localparam int EVNUM_W = 15;
   localparam int SIZE_W  = 16;

   function automatic logic [WORD_W-1:0] make_header(
      input logic               tag_present,
      input logic [EVNUM_W-1:0] evnum,
      input logic [SIZE_W-1:0]  nwords);
      return {tag_present, evnum, nwords};
   endfunction

endpackage

// File: rtl/evscal_chan.sv
module evscal_chan #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             din,
   input  logic             clr,
   input  logic             cap,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] lat
);

   logic s_meta, s_sync, s_prev;
   logic rise;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s_meta <= 1'b0;
         s_sync <= 1'b0;
         s_prev <= 1'b0;
      end else begin
         s_meta <= din;
         s_sync <= s_meta;
         s_prev <= s_sync;
      end
   end

   assign rise = s_sync & ~s_prev;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (clr) begin
         cnt <= rise ? CNT_W'(1) : '0;
      end else if (rise) begin
         cnt <= cnt + CNT_W'(1);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)   lat <= '0;
      else if (cap) lat <= cnt;
   end

   a_r1_single_step: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> (cnt == $past(cnt)) || (cnt == $past(cnt) + CNT_W'(1)));

   a_r2_latch_snapshot: assert property (@(posedge clk) disable iff (!rst_n)
      cap |=> lat == $past(cnt));

   a_r7_edge_on_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && rise) |=> cnt == CNT_W'(1));

endmodule

// File: rtl/evscal_timetag.sv
module evscal_timetag #(
   parameter int TICKS_PER_US = 250,
   parameter int TAG_W        = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [TAG_W-1:0] usec
);

   localparam int PW = (TICKS_PER_US > 1) ? $clog2(TICKS_PER_US) : 1;

   logic [PW-1:0] pre;
   logic          tick;

   generate
      if (TICKS_PER_US == 1) begin : g_direct
         assign tick = 1'b1;
         always_ff @(posedge clk) pre <= '0;
      end else begin : g_prescale
         assign tick = (pre == PW'(TICKS_PER_US - 1));
         always_ff @(posedge clk) begin
            if (!rst_n)    pre <= '0;
            else if (tick) pre <= '0;
            else           pre <= pre + PW'(1);
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)    usec <= '0;
      else if (tick) usec <= usec + TAG_W'(1);
   end

   a_r4_tag_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
      (usec == $past(usec)) || (usec == $past(usec) + TAG_W'(1)));

endmodule

// File: rtl/evscal_fifo.sv
module evscal_fifo #(
   parameter int W     = 32,
   parameter int DEPTH = 64
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [W-1:0]               wr_data,
   input  logic                       pop,
   output logic                       rd_valid,
   output logic [W-1:0]               rd_data,
   output logic [$clog2(DEPTH):0]     free
);

   localparam int PW = $clog2(DEPTH);

   generate
      if ((1 << PW) != DEPTH) begin : g_bad_depth
         $error("evscal_fifo: DEPTH must be a power of two");
      end
   endgenerate

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] wptr, rptr;
   logic [PW:0]   count;
   logic          do_pop;

   assign rd_valid = (count != '0);
   assign do_pop   = pop && rd_valid;
   assign rd_data  = mem[rptr];
   assign free     = (PW+1)'(DEPTH) - count;

   always_ff @(posedge clk) begin
      if (wr_en) mem[wptr] <= wr_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
      end else begin
         if (wr_en)  wptr <= wptr + PW'(1);
         if (do_pop) rptr <= rptr + PW'(1);
         case ({wr_en, do_pop})
            2'b10:   count <= count + (PW+1)'(1);
            2'b01:   count <= count - (PW+1)'(1);
            default: count <= count;
         endcase
      end
   end

   a_r5_no_overfill: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> count < (PW+1)'(DEPTH));

   a_r6_pop_empty_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && (count == '0) && !wr_en) |=> count == '0);

endmodule

// File: rtl/evscal_builder.sv
module evscal_builder
   import evscal_pkg::*;
#(
   parameter int NCH   = 8,
   parameter int CNT_W = 32,
   parameter int TAG_W = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic [NCH-1:0]       mask_in,
   input  logic                 tag_en_in,
   input  logic [TAG_W-1:0]     tag_in,
   input  logic [NCH*CNT_W-1:0] lat_flat,
   output logic                 busy,
   output logic                 wr_en,
   output logic [WORD_W-1:0]    wr_data
);

   localparam int IW = (NCH > 1) ? $clog2(NCH) : 1;

   bld_state_e         state;
   logic [NCH-1:0]     mask_q;
   logic               tag_q;
   logic [TAG_W-1:0]   time_q;
   logic [SIZE_W-1:0]  size_q;
   logic [EVNUM_W-1:0] evnum;
   logic [IW-1:0]      idx;
   logic [SIZE_W-1:0]  size_calc;

   always_comb begin
      size_calc = SIZE_W'(1) + SIZE_W'(tag_en_in);
      for (int i = 0; i < NCH; i++) begin
         size_calc = size_calc + SIZE_W'(mask_in[i]);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= BLD_IDLE;
         mask_q <= '0;
         tag_q  <= 1'b0;
         time_q <= '0;
         size_q <= '0;
         evnum  <= '0;
         idx    <= '0;
      end else begin
         case (state)
            BLD_IDLE: begin
               if (start) begin
                  mask_q <= mask_in;
                  tag_q  <= tag_en_in;
                  time_q <= tag_in;
                  size_q <= size_calc;
                  state  <= BLD_HDR;
               end
            end
            BLD_HDR: begin
               evnum <= evnum + EVNUM_W'(1);
               idx   <= '0;
               state <= tag_q ? BLD_TAG : BLD_DATA;
            end
            BLD_TAG: begin
               state <= BLD_DATA;
            end
            BLD_DATA: begin
               idx <= idx + IW'(1);
               if (idx == IW'(NCH - 1)) state <= BLD_IDLE;
            end
            default: state <= BLD_IDLE;
         endcase
      end
   end

   assign busy = (state != BLD_IDLE);

   always_comb begin
      wr_en   = 1'b0;
      wr_data = '0;
      case (state)
         BLD_HDR: begin
            wr_en   = 1'b1;
            wr_data = make_header(tag_q, evnum, size_q);
         end
         BLD_TAG: begin
            wr_en   = 1'b1;
            wr_data = WORD_W'(time_q);
         end
         BLD_DATA: begin
            wr_en   = mask_q[idx];
            wr_data = WORD_W'(lat_flat[idx*CNT_W +: CNT_W]);
         end
         default: ;
      endcase
   end

   a_r3_header_follows_start: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> wr_en && (wr_data[31] == $past(tag_en_in)));

   a_r5_no_start_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !start);

endmodule

// File: rtl/evscal_top.sv
module evscal_top #(
   parameter int NCH          = 8,
   parameter int CNT_W        = 32,
   parameter int FIFO_DEPTH   = 64,
   parameter int TICKS_PER_US = 250,
   localparam int IW          = (NCH > 1) ? $clog2(NCH) : 1,
   localparam int AW          = IW + 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NCH-1:0]   ch_in,
   input  logic             trig,
   input  logic [NCH-1:0]   chan_mask,
   input  logic             tag_en,
   input  logic             auto_clr,
   input  logic [AW-1:0]    live_addr,
   output logic [CNT_W-1:0] live_data,
   output logic             rd_valid,
   output logic [31:0]      rd_data,
   input  logic             pop,
   output logic             full
);

   localparam int TAG_W = 32;
   localparam int FW    = $clog2(FIFO_DEPTH) + 1;

   generate
      if (NCH < 1) begin : g_bad_nch
         $error("evscal_top: NCH must be at least 1");
      end
      if (CNT_W < 1 || CNT_W > 32) begin : g_bad_cw
         $error("evscal_top: CNT_W must be 1..32");
      end
      if (FIFO_DEPTH < NCH + 2) begin : g_bad_depth
         $error("evscal_top: FIFO_DEPTH must hold one full event");
      end
      if (TICKS_PER_US < 1) begin : g_bad_ticks
         $error("evscal_top: TICKS_PER_US must be positive");
      end
   endgenerate

   logic [NCH*CNT_W-1:0] cnt_flat, lat_flat;
   logic [TAG_W-1:0]     usec;
   logic [FW-1:0]        free;
   logic [FW-1:0]        need;
   logic                 busy, accept, room;
   logic                 wr_en;
   logic [31:0]          wr_data;

   always_comb begin
      need = FW'(2);
      for (int i = 0; i < NCH; i++) begin
         need = need + FW'(chan_mask[i]);
      end
   end

   assign room   = (free >= need);
   assign full   = !room;
   assign accept = rst_n && trig && !busy && room;

   genvar g;
   generate
      for (g = 0; g < NCH; g++) begin : g_chan
         evscal_chan #(.CNT_W(CNT_W)) i_chan (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (ch_in[g]),
            .clr  (accept && auto_clr),
            .cap  (accept),
            .cnt  (cnt_flat[g*CNT_W +: CNT_W]),
            .lat  (lat_flat[g*CNT_W +: CNT_W])
         );
      end
   endgenerate

   evscal_timetag #(.TICKS_PER_US(TICKS_PER_US), .TAG_W(TAG_W)) i_tag (
      .clk  (clk),
      .rst_n(rst_n),
      .usec (usec)
   );

   evscal_builder #(.NCH(NCH), .CNT_W(CNT_W), .TAG_W(TAG_W)) i_bld (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (accept),
      .mask_in  (chan_mask),
      .tag_en_in(tag_en),
      .tag_in   (usec),
      .lat_flat (lat_flat),
      .busy     (busy),
      .wr_en    (wr_en),
      .wr_data  (wr_data)
   );

   evscal_fifo #(.W(32), .DEPTH(FIFO_DEPTH)) i_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .pop     (pop),
      .rd_valid(rd_valid),
      .rd_data (rd_data),
      .free    (free)
   );

   logic [IW-1:0] live_sel;
   assign live_sel = live_addr[AW-1:2];

   always_comb begin
      live_data = '0;
      for (int i = 0; i < NCH; i++) begin
         if (live_sel == IW'(i)) live_data = cnt_flat[i*CNT_W +: CNT_W];
      end
   end

   a_r5_full_refuses: assert property (@(posedge clk) disable iff (!rst_n)
      (full && !busy) |=> !busy);

   a_r9_empty_after_reset: assert property (@(posedge clk)
      !rst_n |=> !rd_valid);

endmodule

// File: tb/test_evscal_top.sv
module test_evscal_top;

   localparam int NCH   = 4;
   localparam int DEPTH = 16;
   localparam int TICKS = 5;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  ch_in = '0;
   logic        trig = 1'b0;
   logic [3:0]  chan_mask = '0;
   logic        tag_en = 1'b0;
   logic        auto_clr = 1'b0;
   logic [3:0]  live_addr = '0;
   logic [31:0] live_data;
   logic        rd_valid;
   logic [31:0] rd_data;
   logic        pop = 1'b0;
   logic        full;

   always #2 clk = ~clk;

   evscal_top #(.NCH(NCH), .CNT_W(32), .FIFO_DEPTH(DEPTH), .TICKS_PER_US(TICKS))
   i_evscal_top (
      .clk(clk), .rst_n(rst_n), .ch_in(ch_in), .trig(trig),
      .chan_mask(chan_mask), .tag_en(tag_en), .auto_clr(auto_clr),
      .live_addr(live_addr), .live_data(live_data), .rd_valid(rd_valid),
      .rd_data(rd_data), .pop(pop), .full(full)
   );

   int total = 0, bad = 0;
   int cyc = 0;
   bit done = 1'b0;
   int exp_cnt [NCH];
   int evnum = 0;

   always @(posedge clk) if (rst_n) cyc <= cyc + 1;

   task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   task automatic pulses(logic [3:0] v);
      @(negedge clk) ch_in = v;
      @(negedge clk) ch_in = '0;
      for (int i = 0; i < NCH; i++) if (v[i]) exp_cnt[i]++;
   endtask

   task automatic settle();
      repeat (4) @(negedge clk);
   endtask

   task automatic fire(output int tcyc);
      @(negedge clk) trig = 1'b1;
      tcyc = cyc;
      @(negedge clk) trig = 1'b0;
   endtask

   task automatic wait_build();
      repeat (NCH + 4) @(negedge clk);
   endtask

   task automatic pop_word(output logic [31:0] w, output bit v);
      @(negedge clk);
      v = rd_valid;
      w = rd_data;
      if (v) pop = 1'b1;
      @(negedge clk) pop = 1'b0;
   endtask

   task automatic check_live(string req);
      for (int i = 0; i < NCH; i++) begin
         @(negedge clk) live_addr = 4'(i * 4 + (i % 4));
         #1 chk(live_data == 32'(exp_cnt[i]), req, live_data, 32'(exp_cnt[i]));
      end
   endtask

   task automatic read_event(logic [3:0] m, bit te, int snap [NCH], int evn, int tcyc);
      logic [31:0] w;
      bit v;
      int nwords;
      nwords = 1 + int'(te);
      for (int i = 0; i < NCH; i++) nwords += int'(m[i]);
      pop_word(w, v);
      chk(v, "R6 header present", 32'(v), 1);
      chk(w[31] == te, "R3 tag flag", 32'(w[31]), 32'(te));
      chk(w[30:16] == 15'(evn), "R3 event number", 32'(w[30:16]), 32'(evn));
      chk(w[15:0] == 16'(nwords), "R3 event size", 32'(w[15:0]), 32'(nwords));
      if (te) begin
         pop_word(w, v);
         chk(v && (int'(w) >= tcyc / TICKS - 1) && (int'(w) <= tcyc / TICKS + 1),
             "R4 time tag", w, 32'(tcyc / TICKS));
      end
      for (int i = 0; i < NCH; i++) begin
         if (m[i]) begin
            pop_word(w, v);
            chk(v && w == 32'(snap[i]), "R2 R3 channel value", w, 32'(snap[i]));
         end
      end
   endtask

   initial begin
      #800000;
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int snap [NCH];
      int tc, tc2, tc3;
      logic [31:0] w;
      bit v;
      for (int i = 0; i < NCH; i++) exp_cnt[i] = 0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R9 reset state
      chk(!rd_valid, "R9 fifo empty", 32'(rd_valid), 0);
      chk(!full, "R9 full low", 32'(full), 0);
      check_live("R9 counters zero");

      // Mask sweep: R1, R2, R3, R8
      for (int m = 0; m < 16; m++) begin
         chan_mask = 4'(m);
         tag_en = m[0];
         for (int p = 0; p <= (m % 3) + 1; p++) pulses(4'((m + p) | 1));
         settle();
         check_live("R1 R8 live count");
         fire(tc);
         for (int i = 0; i < NCH; i++) snap[i] = exp_cnt[i];
         pulses(4'hF);
         wait_build();
         read_event(4'(m), m[0], snap, evnum, tc);
         evnum++;
         check_live("R2 counting continues");
      end

      // Room boundary: R5
      chan_mask = 4'hF;
      tag_en = 1'b1;
      fire(tc);  wait_build();
      fire(tc2); wait_build();
      for (int i = 0; i < NCH; i++) snap[i] = exp_cnt[i];
      #1 chk(full, "R5 full with 4 free need 6", 32'(full), 1);
      fire(tc3); wait_build();
      chan_mask = 4'h3;
      #1 chk(!full, "R5 exact room not full", 32'(full), 0);
      fire(tc3); wait_build();
      read_event(4'hF, 1'b1, snap, evnum, tc);
      read_event(4'hF, 1'b1, snap, evnum + 1, tc2);
      read_event(4'h3, 1'b1, snap, evnum + 2, tc3);
      evnum += 3;
      @(negedge clk);
      chk(!rd_valid, "R5 refused trigger left no event", 32'(rd_valid), 0);
      // R6 pop on empty
      pop_word(w, v);
      chk(!v && !rd_valid, "R6 pop on empty ignored", 32'(rd_valid), 0);
      chan_mask = 4'h5;
      tag_en = 1'b0;
      fire(tc); wait_build();
      read_event(4'h5, 1'b0, snap, evnum, tc);
      evnum++;

      // Auto-clear: R7
      auto_clr = 1'b1;
      chan_mask = 4'hF;
      fire(tc); wait_build();
      read_event(4'hF, 1'b0, snap, evnum, tc);
      evnum++;
      for (int i = 0; i < NCH; i++) exp_cnt[i] = 0;
      pulses(4'h3); pulses(4'h1); pulses(4'h1);
      settle();
      for (int i = 0; i < NCH; i++) snap[i] = exp_cnt[i];
      fire(tc); wait_build();
      read_event(4'hF, 1'b0, snap, evnum, tc);
      evnum++;
      // edge landing on the clear edge (R7)
      @(negedge clk) ch_in = 4'h4;
      @(negedge clk);
      @(negedge clk) trig = 1'b1;
      tc = cyc;
      @(negedge clk) begin trig = 1'b0; ch_in = '0; end
      for (int i = 0; i < NCH; i++) snap[i] = 0;
      wait_build();
      read_event(4'hF, 1'b0, snap, evnum, tc);
      evnum++;
      for (int i = 0; i < NCH; i++) exp_cnt[i] = (i == 2) ? 1 : 0;
      check_live("R7 edge on clear counted");
      for (int i = 0; i < NCH; i++) snap[i] = exp_cnt[i];
      fire(tc); wait_build();
      read_event(4'hF, 1'b0, snap, evnum, tc);
      evnum++;

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule